// File: doc/BRIEF.md
# Auto-Detecting Slave Bus Decoder

This block sits on the slave side of a peripheral's host-bus port. It works out whether the host bus shares its lines between address and data. It does this by watching the address strobe from reset until software writes the bus configuration register. It then turns each host access into a one-hot select for one of four targets: the serial data FIFOs, the serial control registers, the transmit DMA registers or the receive DMA registers. Alongside the select it gives a register index, a read/write flag and a one-cycle pulse that tells the target when to capture write data.

All host pins enter the system clock domain through two-flop synchronizers. Edges are found on the synchronized copies. Two strobe styles are accepted at the same time: separate read and write strobes, or a single data strobe with a read/write level. On a shared address/data bus, the section pin, the kind pin and the low address bits are captured when the address strobe rises. On a dedicated bus, the section and kind pins are taken when the data strobe starts, and the index comes from a command register that software has loaded. The first bus configuration write also stores the handshake style, and from then on neither the mode nor the style can change until reset.

Top module: `bus_slave_decoder`

## Requirements
- R1: After reset, sel_o is 0, wcap_o is 0, mux_o is 0 (dedicated bus) and hs_ack_o is 0 (wait style).
- R2: An access starts when any of ds_ni, rd_ni or wr_ni falls. If cs_ni is low, intack_ni is high and the section is serial (sect_i high), the select depends on kind_i. kind_i high selects the data FIFOs (sel_o = 4'b0001). kind_i low selects the serial control registers (sel_o = 4'b0010).
- R3: With cs_ni low, intack_ni high and the section DMA (sect_i low), kind_i picks the channel. Low selects transmit DMA (sel_o = 4'b0100). High selects receive DMA (sel_o = 4'b1000).
- R4: An access with cs_ni high, or with intack_ni low, asserts no select and produces no write-capture pulse.
- R5: A falling edge on as_ni before the bus configuration write is locked sets mux_o to 1, and mux_o stays 1 until reset.
- R6: When mux_o is 1, three values come from the levels present when as_ni rose: the section, the kind and the register index (ad_lo_i). Changes on those pins after that edge do not affect the access.
- R7: When mux_o is 0, the section and kind levels are taken at the start of the strobe, and later changes are ignored. idx_o is taken from cmd_idx_i.
- R8: wr_o is 1 for a write and 0 for a read, and is held while a select is asserted. A write is wr_ni low, or ds_ni low with rw_i low, at the start of the strobe.
- R9: When the strobe ends, all selects clear. If the access was a selected write, wcap_o pulses high for exactly one cycle.
- R10: The bus configuration write is a write to the serial control registers with index BCR_IDX (default 0). At the end of that write the block locks. hs_ack_o takes the sect_i level at that moment (1 = acknowledge style). After the lock, neither mux_o nor hs_ack_o changes until reset, even if more such writes or address-strobe edges arrive.
- R11: Each output responds on the third rising clock edge after the pin change that causes it: two synchronizer stages plus one registered edge stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| intack_ni | input | 1 | Interrupt acknowledge, active low (high qualifies register access) |
| sect_i | input | 1 | Section: high serial, low DMA |
| kind_i | input | 1 | Serial: high data FIFO, low control; DMA: low transmit, high receive |
| as_ni | input | 1 | Address strobe, active low |
| ds_ni | input | 1 | Data strobe, active low |
| rw_i | input | 1 | Read/write level for the data-strobe style, low = write |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| ad_lo_i | input | IDX_W | Low-order address/data lines |
| cmd_idx_i | input | IDX_W | Register index from the command register (dedicated bus) |
| sel_o | output | 4 | One-hot target select: bit0 FIFO, bit1 serial control, bit2 transmit DMA, bit3 receive DMA |
| idx_o | output | IDX_W | Register index of the current access |
| wr_o | output | 1 | Current access is a write |
| wcap_o | output | 1 | One-cycle write-data capture pulse |
| mux_o | output | 1 | Shared address/data bus detected |
| hs_ack_o | output | 1 | Stored handshake style, 1 = acknowledge |

## Verification
A wrong mode or lock bit would show up as a wrong target or a wrong index. It appears on the first access after a held or changed address-strobe latch, because that access would decode the live pins instead of the latched ones, or the reverse. A mistimed edge stage or synchronizer would show as a select, a clear or a capture pulse that moves by one cycle from the third-edge timing. A reference model compared on every clock reports that in the cycle it happens. A lock that fails to hold would show as mux_o or hs_ack_o changing on the first address strobe or configuration write after the lock. The bench provokes both of these cases on purpose.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef struct packed {
    logic cs_n;
    logic intack_n;
    logic sect;
    logic kind;
    logic as_n;
    logic ds_n;
    logic rw;
    logic rd_n;
    logic wr_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, intack_n: 1'b1, sect: 1'b0, kind: 1'b0,
                                  as_n: 1'b1, ds_n: 1'b1, rw: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

  localparam int unsigned NTGT = 4;

  typedef enum logic [1:0] {
    TGT_FIFO  = 2'd0,
    TGT_SCTL  = 2'd1,
    TGT_TXDMA = 2'd2,
    TGT_RXDMA = 2'd3
  } tgt_e;
endpackage

// File: rtl/bsd_sync.sv
module bsd_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      q_o  <= RST;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/bsd_mode.sv
module bsd_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_fall_i,
  input  logic cfg_done_i,
  input  logic sect_i,
  output logic mux_o,
  output logic hs_ack_o
);
  logic locked_q;

  // mode learned from strobe activity, frozen by first config write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_o    <= 1'b0;
      hs_ack_o <= 1'b0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      if (as_fall_i) mux_o <= 1'b1;
      if (cfg_done_i) begin
        locked_q <= 1'b1;
        hs_ack_o <= sect_i;
      end
    end
  end
endmodule

// File: rtl/bsd_decode.sv
module bsd_decode import bsd_pkg::*; #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned BCR_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mux_i,
  input  logic             as_rise_i,
  input  logic             st_fall_i,
  input  logic             st_rise_i,
  input  logic             cs_n_i,
  input  logic             intack_n_i,
  input  logic             sect_i,
  input  logic             kind_i,
  input  logic             ds_n_i,
  input  logic             rw_i,
  input  logic             wr_n_i,
  input  logic [IDX_W-1:0] ad_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  output logic [NTGT-1:0]  sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wr_o,
  output logic             wcap_o,
  output logic             cfg_done_o
);
  localparam logic [IDX_W-1:0] CFG_IDX = IDX_W'(BCR_IDX);

  logic             lat_sect_q, lat_kind_q;
  logic [IDX_W-1:0] lat_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_sect_q <= 1'b0;
      lat_kind_q <= 1'b0;
      lat_idx_q  <= '0;
    end else if (as_rise_i) begin
      lat_sect_q <= sect_i;
      lat_kind_q <= kind_i;
      lat_idx_q  <= ad_i;
    end
  end

  logic             sect_eff, kind_eff, hit, is_wr;
  logic [IDX_W-1:0] idx_eff;
  tgt_e             tgt;
  logic [NTGT-1:0]  sel_d;

  always_comb begin
    sect_eff = mux_i ? lat_sect_q : sect_i;
    kind_eff = mux_i ? lat_kind_q : kind_i;
    idx_eff  = mux_i ? lat_idx_q  : cmd_idx_i;
    hit      = !cs_n_i && intack_n_i;
    is_wr    = !wr_n_i || (!ds_n_i && !rw_i);
    if (sect_eff) tgt = kind_eff ? TGT_FIFO  : TGT_SCTL;
    else          tgt = kind_eff ? TGT_RXDMA : TGT_TXDMA;
  end

  for (genvar g = 0; g < NTGT; g++) begin : g_sel
    assign sel_d[g] = hit && (tgt == tgt_e'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= '0;
      idx_o  <= '0;
      wr_o   <= 1'b0;
      wcap_o <= 1'b0;
    end else if (st_fall_i) begin
      sel_o  <= sel_d;
      idx_o  <= idx_eff;
      wr_o   <= is_wr;
      wcap_o <= 1'b0;
    end else if (st_rise_i) begin
      wcap_o <= wr_o && (|sel_o);
      sel_o  <= '0;
    end else begin
      wcap_o <= 1'b0;
    end
  end

  assign cfg_done_o = st_rise_i && sel_o[TGT_SCTL] && wr_o && (idx_o == CFG_IDX);
endmodule

// File: rtl/bus_slave_decoder.sv
module bus_slave_decoder import bsd_pkg::*; #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned BCR_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             intack_ni,
  input  logic             sect_i,
  input  logic             kind_i,
  input  logic             as_ni,
  input  logic             ds_ni,
  input  logic             rw_i,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [IDX_W-1:0] ad_lo_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  output logic [NTGT-1:0]  sel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wr_o,
  output logic             wcap_o,
  output logic             mux_o,
  output logic             hs_ack_o
);
  localparam int unsigned PW = $bits(pins_t);
  localparam int unsigned SW = PW + IDX_W;

  pins_t            pins_raw, pins_s;
  logic [SW-1:0]    sync_q;
  logic [IDX_W-1:0] ad_s;

  assign pins_raw = '{cs_n: cs_ni, intack_n: intack_ni, sect: sect_i, kind: kind_i,
                      as_n: as_ni, ds_n: ds_ni, rw: rw_i, rd_n: rd_ni, wr_n: wr_ni};

  bsd_sync #(.W(SW), .RST({PINS_IDLE, {IDX_W{1'b0}}})) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pins_raw, ad_lo_i}),
    .q_o   (sync_q)
  );

  assign pins_s = pins_t'(sync_q[SW-1:IDX_W]);
  assign ad_s   = sync_q[IDX_W-1:0];

  // any strobe style opens an access
  logic strb_s, strb_prev_q, as_prev_q;
  logic as_fall, as_rise, st_fall, st_rise;

  assign strb_s = pins_s.ds_n & pins_s.rd_n & pins_s.wr_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_prev_q <= 1'b1;
      as_prev_q   <= 1'b1;
    end else begin
      strb_prev_q <= strb_s;
      as_prev_q   <= pins_s.as_n;
    end
  end

  assign as_fall = as_prev_q & ~pins_s.as_n;
  assign as_rise = ~as_prev_q & pins_s.as_n;
  assign st_fall = strb_prev_q & ~strb_s;
  assign st_rise = ~strb_prev_q & strb_s;

  logic cfg_done;

  bsd_decode #(.IDX_W(IDX_W), .BCR_IDX(BCR_IDX)) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mux_i     (mux_o),
    .as_rise_i (as_rise),
    .st_fall_i (st_fall),
    .st_rise_i (st_rise),
    .cs_n_i    (pins_s.cs_n),
    .intack_n_i(pins_s.intack_n),
    .sect_i    (pins_s.sect),
    .kind_i    (pins_s.kind),
    .ds_n_i    (pins_s.ds_n),
    .rw_i      (pins_s.rw),
    .wr_n_i    (pins_s.wr_n),
    .ad_i      (ad_s),
    .cmd_idx_i (cmd_idx_i),
    .sel_o     (sel_o),
    .idx_o     (idx_o),
    .wr_o      (wr_o),
    .wcap_o    (wcap_o),
    .cfg_done_o(cfg_done)
  );

  bsd_mode u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .as_fall_i (as_fall),
    .cfg_done_i(cfg_done),
    .sect_i    (pins_s.sect),
    .mux_o     (mux_o),
    .hs_ack_o  (hs_ack_o)
  );
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker import bsd_pkg::*; #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned BCR_IDX = 0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NTGT-1:0]  sel_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             wr_i,
  input logic             wcap_i,
  input logic             mux_i,
  input logic             hs_i
);
  logic [NTGT-1:0]  sel_d;
  logic [IDX_W-1:0] idx_d;
  logic             wr_d, lk_q;

  // lock observed independently from the port-level config write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_d <= '0;
      idx_d <= '0;
      wr_d  <= 1'b0;
      lk_q  <= 1'b0;
    end else begin
      sel_d <= sel_i;
      idx_d <= idx_i;
      wr_d  <= wr_i;
      if (wcap_i && sel_d == 4'b0010 && wr_d && idx_d == IDX_W'(BCR_IDX)) lk_q <= 1'b1;
    end
  end

  a_r2_onehot_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));

  a_r9_cap_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcap_i |=> !wcap_i);

  a_r9_sel_clear_on_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcap_i |-> (sel_i == '0));

  a_r9_cap_after_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcap_i |-> $past(|sel_i));

  a_r5_mux_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_i |=> mux_i);

  a_r8_wr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sel_i) && $past(|sel_i)) |-> $stable(wr_i));

  a_r10_lock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_q |=> ($stable(mux_i) && $stable(hs_i)));
endmodule

bind bus_slave_decoder bsd_checker #(.IDX_W(IDX_W), .BCR_IDX(BCR_IDX)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sel_i (sel_o),
  .idx_i (idx_o),
  .wr_i  (wr_o),
  .wcap_i(wcap_o),
  .mux_i (mux_o),
  .hs_i  (hs_ack_o)
);

// File: tb/bus_slave_decoder_bench.sv
`timescale 1ns/1ps
module bus_slave_decoder_bench;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cs_n = 1, ia_n = 1, sect = 0, kind = 0, as_n = 1, ds_n = 1, rw = 1, rd_n = 1, wr_n = 1;
  logic [IW-1:0] ad = '0, cmd_idx = '0;

  logic [3:0]    sel_o;
  logic [IW-1:0] idx_o;
  logic wr_o, wcap_o, mux_o, hs_ack_o;

  bus_slave_decoder #(.IDX_W(IW), .BCR_IDX(0)) u_bus_slave_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .intack_ni(ia_n), .sect_i(sect), .kind_i(kind),
    .as_ni(as_n), .ds_ni(ds_n), .rw_i(rw), .rd_ni(rd_n), .wr_ni(wr_n), .ad_lo_i(ad),
    .cmd_idx_i(cmd_idx), .sel_o(sel_o), .idx_o(idx_o), .wr_o(wr_o), .wcap_o(wcap_o),
    .mux_o(mux_o), .hs_ack_o(hs_ack_o));

  int total = 0, bad = 0, wcap_cnt = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: pin history, three-edge response
  typedef struct packed {
    logic cs_n, ia_n, sect, kind, as_n, ds_n, rw, rd_n, wr_n;
    logic [IW-1:0] ad;
  } snap_t;
  localparam snap_t IDLE = '{cs_n:1'b1, ia_n:1'b1, sect:1'b0, kind:1'b0, as_n:1'b1,
                             ds_n:1'b1, rw:1'b1, rd_n:1'b1, wr_n:1'b1, ad:'0};
  snap_t hist [4];
  logic [3:0] m_sel;
  logic [IW-1:0] m_idx, m_lidx;
  logic m_wr, m_wcap, m_mux, m_hs, m_lock, m_lsect, m_lkind;

  always @(posedge clk or negedge rst_n) begin
    snap_t o, n;
    logic so, sn, s, k;
    logic [3:0] x_sel;
    logic [IW-1:0] x_idx, x_lidx;
    logic x_wr, x_wcap, x_mux, x_hs, x_lock, x_lsect, x_lkind;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hist[i] = IDLE;
      m_sel = 0; m_idx = 0; m_lidx = 0; m_wr = 0; m_wcap = 0; m_mux = 0; m_hs = 0;
      m_lock = 0; m_lsect = 0; m_lkind = 0;
    end else begin
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0];
      hist[0] = '{cs_n:cs_n, ia_n:ia_n, sect:sect, kind:kind, as_n:as_n, ds_n:ds_n,
                  rw:rw, rd_n:rd_n, wr_n:wr_n, ad:ad};
      o = hist[3]; n = hist[2];
      so = o.ds_n & o.rd_n & o.wr_n;
      sn = n.ds_n & n.rd_n & n.wr_n;
      x_sel = m_sel; x_idx = m_idx; x_lidx = m_lidx; x_wr = m_wr; x_wcap = 0;
      x_mux = m_mux; x_hs = m_hs; x_lock = m_lock; x_lsect = m_lsect; x_lkind = m_lkind;
      if (o.as_n && !n.as_n && !m_lock) x_mux = 1;
      if (!o.as_n && n.as_n) begin x_lsect = n.sect; x_lkind = n.kind; x_lidx = n.ad; end
      if (so && !sn) begin
        s = m_mux ? m_lsect : n.sect;
        k = m_mux ? m_lkind : n.kind;
        if (!n.cs_n && n.ia_n) x_sel = s ? (k ? 4'b0001 : 4'b0010) : (k ? 4'b1000 : 4'b0100);
        else x_sel = 0;
        x_idx = m_mux ? m_lidx : cmd_idx;
        x_wr = !n.wr_n || (!n.ds_n && !n.rw);
      end else if (!so && sn) begin
        x_wcap = m_wr && (m_sel != 0);
        if (m_sel == 4'b0010 && m_wr && m_idx == 0 && !m_lock) begin x_lock = 1; x_hs = n.sect; end
        x_sel = 0;
      end
      m_sel = x_sel; m_idx = x_idx; m_lidx = x_lidx; m_wr = x_wr; m_wcap = x_wcap;
      m_mux = x_mux; m_hs = x_hs; m_lock = x_lock; m_lsect = x_lsect; m_lkind = x_lkind;
    end
  end

  // R11: per-clock comparison against the model
  always @(negedge clk) if (rst_n && !finished) begin
    if (wcap_o) wcap_cnt++;
    chk("R11 sel", sel_o, m_sel);
    chk("R11 wcap", wcap_o, m_wcap);
    chk("R11 mux", mux_o, m_mux);
    chk("R11 hs", hs_ack_o, m_hs);
    if (m_sel != 0) begin
      chk("R11 idx", idx_o, m_idx);
      chk("R11 wr", wr_o, m_wr);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; cs_n = 1; ia_n = 1; sect = 0; kind = 0; as_n = 1; ds_n = 1; rw = 1;
    rd_n = 1; wr_n = 1; ad = 0;
    tick(3); rst_n = 1; tick(2);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=expired exp=done");
    finish_run();
  end

  initial begin
    cmd_idx = 5;
    do_reset();
    chk("R1 sel", sel_o, 0); chk("R1 wcap", wcap_o, 0);
    chk("R1 mux", mux_o, 0); chk("R1 hs", hs_ack_o, 0);

    // data-strobe read of the FIFO, dedicated bus
    cs_n = 0; sect = 1; kind = 1; rw = 1; tick(1);
    ds_n = 0; tick(5);
    chk("R2 fifo sel", sel_o, 1); chk("R8 read wr", wr_o, 0); chk("R7 cmd idx", idx_o, 5);
    sect = 0; kind = 0; tick(4);
    chk("R7 late pins ignored", sel_o, 1);
    ds_n = 1; tick(5);
    chk("R9 sel clear", sel_o, 0); chk("R9 no cap on read", wcap_cnt, 0);
    cs_n = 1; tick(2);

    // write-strobe write to serial control, not the config index
    cs_n = 0; sect = 1; kind = 0; tick(1);
    wr_n = 0; tick(5);
    chk("R2 sctl sel", sel_o, 2); chk("R8 wr strobe", wr_o, 1);
    wr_n = 1; tick(5);
    chk("R9 cap count", wcap_cnt, 1); chk("R10 no lock idx5", hs_ack_o, 0);
    cs_n = 1; tick(2);

    // read-strobe read of transmit DMA
    cs_n = 0; sect = 0; kind = 0; tick(1);
    rd_n = 0; tick(5);
    chk("R3 tx sel", sel_o, 4); chk("R8 rd strobe", wr_o, 0);
    rd_n = 1; tick(5); cs_n = 1; tick(2);

    // data-strobe write to receive DMA
    cs_n = 0; sect = 0; kind = 1; rw = 0; tick(1);
    ds_n = 0; tick(5);
    chk("R3 rx sel", sel_o, 8); chk("R8 rw write", wr_o, 1);
    ds_n = 1; tick(5); chk("R9 cap count", wcap_cnt, 2);
    cs_n = 1; rw = 1; tick(2);

    // unqualified accesses
    sect = 1; kind = 1; rw = 0; tick(1);
    ds_n = 0; tick(5); chk("R4 cs high", sel_o, 0);
    ds_n = 1; tick(3);
    cs_n = 0; ia_n = 0; tick(1);
    ds_n = 0; tick(5); chk("R4 intack low", sel_o, 0);
    ds_n = 1; tick(5); chk("R4 no cap", wcap_cnt, 2);
    cs_n = 1; ia_n = 1; tick(2);

    // config write, dedicated bus: lock with acknowledge style
    cmd_idx = 0; sect = 1; kind = 0; rw = 0; cs_n = 0; tick(1);
    ds_n = 0; tick(5); chk("R10 cfg sel", sel_o, 2);
    ds_n = 1; tick(5);
    chk("R10 hs stored", hs_ack_o, 1); chk("R10 mode", mux_o, 0);
    tick(1); ds_n = 0; tick(3); sect = 0; tick(2);
    ds_n = 1; tick(5); chk("R10 second cfg ignored", hs_ack_o, 1);
    cs_n = 1; rw = 1; tick(1);
    as_n = 0; tick(3); as_n = 1; tick(4);
    chk("R10 as after lock", mux_o, 0);

    // shared bus path
    do_reset();
    chk("R1 hs after reset", hs_ack_o, 0); chk("R1 mux after reset", mux_o, 0);
    cmd_idx = 9; ad = 3; sect = 0; kind = 1; tick(1);
    as_n = 0; tick(3); chk("R5 mux detect", mux_o, 1);
    as_n = 1; tick(3);
    ad = 7; sect = 1; kind = 0; cs_n = 0; rw = 0; tick(1);
    ds_n = 0; tick(5);
    chk("R6 latched target", sel_o, 8); chk("R6 latched idx", idx_o, 3);
    ds_n = 1; tick(5); cs_n = 1; tick(2);

    // config write on shared bus; style from live level at the end
    ad = 0; sect = 1; kind = 0; tick(1);
    as_n = 0; tick(3); as_n = 1; tick(3);
    sect = 0; cs_n = 0; tick(1);
    ds_n = 0; tick(5);
    chk("R6 cfg latched sel", sel_o, 2); chk("R6 cfg idx", idx_o, 0);
    sect = 1; tick(3);
    ds_n = 1; tick(5);
    chk("R10 hs shared", hs_ack_o, 1); chk("R5 mux sticky", mux_o, 1);
    cs_n = 1; rw = 1; tick(4);

    finish_run();
  end
endmodule